// File: doc/BRIEF.md
# Digital frequency-locked loop controller

This block closes the digital half of a frequency-locked loop. It runs in the reference clock domain. Over a measurement window of a programmable number of reference cycles, it counts edges of the oscillator under control, which arrive as a strobe that has already been synchronised. When the window closes, the block subtracts an expected count from the oscillator count and adds a signed, programmable offset. It then holds this corrected error until the next window closes.

A first-order sigma-delta modulator turns the held error into a pulse-density command for an external charge pump. That modulator has one saturating accumulator and a three-level decision against a fixed threshold. A positive error density produces UP pulses and a negative error density produces DOWN pulses. Because of the offset, the loop settles at a chosen frequency offset rather than at zero error, and the reference clock does not have to change. A lock monitor watches the per-window error against a tolerance and raises a flag after a run of good windows.

The lock monitor is a three-state machine:
- `LK_IDLE` is held while enable is low.
- `LK_IDLE` moves to `LK_HUNT` on the first enabled cycle.
- `LK_HUNT` moves to `LK_LOCKED` when the fourth consecutive window closes within tolerance. A window outside tolerance in `LK_HUNT` restarts the run count.
- `LK_LOCKED` moves back to `LK_HUNT` on the first window outside tolerance.
- Any state moves to `LK_IDLE` when enable falls.

Top module: `freq_lock_ctrl`

## Requirements
- R1: A window is `win_len` enabled reference cycles, with 0 treated as 1. Each cycle counts at most one strobe. On the last cycle of a window, the corrected error is latched and both counters restart on the same edge. Between window closes the latched error does not change.
- R2: The corrected error is the oscillator count minus `exp_cnt`, taken modulo 2^17 and read as a 17-bit two's-complement value. The signed 17-bit `offset` is then added, giving an 18-bit signed result.
- R3: With a constant corrected error E and threshold THR (default 256), any run of L cycles carries L*|E|/THR pulses within ±1. The pulses are on `up` for E>0 and on `dn` for E<0. E=0 gives no pulses.
- R4: The 24-bit modulator accumulator saturates instead of wrapping. With a large positive error held for many cycles, `up` stays high on every cycle and `dn` never appears.
- R5: `up` and `dn` are never high on the same cycle.
- R6: While `en` is low, `up`, `dn` and `locked` are low from the next cycle, whatever the strobe does. Low `en` clears the counters, the latched error and the accumulator, so the first window after re-enabling produces no pulses.
- R7: `locked` rises one cycle after the fourth consecutive window close whose corrected error magnitude is at most `tol`, with equality counting as good. Fewer good windows leave it low.
- R8: `locked` falls one cycle after a window closes with a corrected error magnitude above `tol`.
- R9: During reset, `up`, `dn` and `locked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Loop enable; low clears all state |
| osc_stb | input | 1 | One-cycle strobe per oscillator edge, reference domain |
| win_len | input | 16 | Window length in reference cycles (0 acts as 1) |
| exp_cnt | input | 17 | Expected oscillator count per window |
| offset | input | 17 | Signed offset added to the count difference |
| tol | input | 17 | Error magnitude tolerance for lock |
| up | output | 1 | Charge-pump raise pulse |
| dn | output | 1 | Charge-pump lower pulse |
| locked | output | 1 | Frequency lock flag |

## Verification
The corrected error is latched on the edge that closes a window. The modulator reacts from the following edge, and the lock flag changes one edge after the close. Each pulse-density check is therefore a count taken at falling edges over a span that begins at least two full windows after enable, when the held error is constant. The expected count carries a ±1 allowance for accumulator phase. Lock checks sample in the middle of a window, far from either close, so the one-cycle lag can never land on the sampled edge. Tests of the disabled state count pulses over the whole disabled span and over the first two windows after re-enable.

// File: rtl/flc_pkg.sv
package flc_pkg;
    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_HUNT   = 2'd1,
        LK_LOCKED = 2'd2
    } lock_state_t;
endpackage

// File: rtl/flc_window.sv
module flc_window #(
    parameter int CNT_W = 17,
    parameter int WIN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    osc_stb,
    input  logic [WIN_W-1:0]        win_len,
    input  logic [CNT_W-1:0]        exp_cnt,
    input  logic [CNT_W-1:0]        offset,
    output logic                    win_done,
    output logic signed [CNT_W:0]   err_q
);
    localparam int RW = WIN_W + 1;

    logic [WIN_W-1:0]      ref_cnt;
    logic [CNT_W-1:0]      osc_cnt;
    logic [RW-1:0]         ref_next;
    logic                  last;
    logic [CNT_W-1:0]      osc_total;
    logic [CNT_W-1:0]      diff;
    logic signed [CNT_W:0] corr;

    assign ref_next  = {1'b0, ref_cnt} + RW'(1);
    assign last      = ref_next >= {1'b0, win_len};
    assign osc_total = osc_cnt + CNT_W'(osc_stb);
    assign diff      = osc_total - exp_cnt;
    assign corr      = {diff[CNT_W-1], diff} + {offset[CNT_W-1], offset};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt  <= '0;
            osc_cnt  <= '0;
            err_q    <= '0;
            win_done <= 1'b0;
        end else if (!en) begin
            ref_cnt  <= '0;
            osc_cnt  <= '0;
            err_q    <= '0;
            win_done <= 1'b0;
        end else if (last) begin
            ref_cnt  <= '0;
            osc_cnt  <= '0;
            err_q    <= corr;
            win_done <= 1'b1;
        end else begin
            ref_cnt  <= ref_next[WIN_W-1:0];
            osc_cnt  <= osc_total;
            win_done <= 1'b0;
        end
    end
endmodule

// File: rtl/flc_sdm.sv
module flc_sdm #(
    parameter int ERR_W = 18,
    parameter int ACC_W = 24,
    parameter int THR   = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [ERR_W-1:0] err,
    output logic                    up,
    output logic                    dn
);
    localparam int SUM_W = ACC_W + 1;
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (ACC_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);
    localparam logic signed [ACC_W-1:0] THR_P  = ACC_W'(THR);
    localparam logic signed [ACC_W-1:0] THR_N  = -THR_P;

    logic signed [ACC_W-1:0] acc, acc_sat, acc_n;
    logic signed [SUM_W-1:0] sum;
    logic                    up_n, dn_n;

    always_comb begin
        sum = {acc[ACC_W-1], acc} + {{(SUM_W - ERR_W){err[ERR_W-1]}}, err};
        if (sum > SAT_HI)
            acc_sat = SAT_HI[ACC_W-1:0];
        else if (sum < SAT_LO)
            acc_sat = SAT_LO[ACC_W-1:0];
        else
            acc_sat = sum[ACC_W-1:0];
        up_n  = 1'b0;
        dn_n  = 1'b0;
        acc_n = acc_sat;
        if (acc_sat >= THR_P) begin
            up_n  = 1'b1;
            acc_n = acc_sat - THR_P;
        end else if (acc_sat <= THR_N) begin
            dn_n  = 1'b1;
            acc_n = acc_sat + THR_P;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            up  <= 1'b0;
            dn  <= 1'b0;
        end else if (!en) begin
            acc <= '0;
            up  <= 1'b0;
            dn  <= 1'b0;
        end else begin
            acc <= acc_n;
            up  <= up_n;
            dn  <= dn_n;
        end
    end
endmodule

// File: rtl/flc_lock.sv
module flc_lock
    import flc_pkg::*;
#(
    parameter int ERR_W     = 18,
    parameter int LOCK_WINS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    win_done,
    input  logic signed [ERR_W-1:0] err,
    input  logic [ERR_W-2:0]        tol,
    output logic                    locked
);
    localparam int GW = $clog2(LOCK_WINS + 1);

    lock_state_t      state, state_n;
    logic [GW-1:0]    good_cnt, good_cnt_n;
    logic [ERR_W-1:0] mag;
    logic             good;

    assign mag  = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
    assign good = mag <= {1'b0, tol};

    always_comb begin
        state_n    = state;
        good_cnt_n = good_cnt;
        if (!en) begin
            state_n    = LK_IDLE;
            good_cnt_n = '0;
        end else begin
            unique case (state)
                LK_IDLE: begin
                    state_n    = LK_HUNT;
                    good_cnt_n = '0;
                end
                LK_HUNT: begin
                    if (win_done) begin
                        if (!good) begin
                            good_cnt_n = '0;
                        end else if (good_cnt == GW'(LOCK_WINS - 1)) begin
                            state_n    = LK_LOCKED;
                            good_cnt_n = '0;
                        end else begin
                            good_cnt_n = good_cnt + GW'(1);
                        end
                    end
                end
                LK_LOCKED: begin
                    good_cnt_n = '0;
                    if (win_done && !good) state_n = LK_HUNT;
                end
                default: begin
                    state_n    = LK_IDLE;
                    good_cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= LK_IDLE;
            good_cnt <= '0;
        end else begin
            state    <= state_n;
            good_cnt <= good_cnt_n;
        end
    end

    always_comb begin
        locked = (state == LK_LOCKED);
    end
endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl #(
    parameter int CNT_W     = 17,
    parameter int WIN_W     = 16,
    parameter int ACC_W     = 24,
    parameter int THR       = 256,
    parameter int LOCK_WINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             osc_stb,
    input  logic [WIN_W-1:0] win_len,
    input  logic [CNT_W-1:0] exp_cnt,
    input  logic [CNT_W-1:0] offset,
    input  logic [CNT_W-1:0] tol,
    output logic             up,
    output logic             dn,
    output logic             locked
);
    localparam int ERR_W = CNT_W + 1;

    logic                    win_done;
    logic signed [ERR_W-1:0] err_q;

    flc_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .en(en), .osc_stb(osc_stb),
        .win_len(win_len), .exp_cnt(exp_cnt), .offset(offset),
        .win_done(win_done), .err_q(err_q)
    );

    flc_sdm #(.ERR_W(ERR_W), .ACC_W(ACC_W), .THR(THR)) u_sdm (
        .clk(clk), .rst_n(rst_n), .en(en), .err(err_q),
        .up(up), .dn(dn)
    );

    flc_lock #(.ERR_W(ERR_W), .LOCK_WINS(LOCK_WINS)) u_lock (
        .clk(clk), .rst_n(rst_n), .en(en), .win_done(win_done),
        .err(err_q), .tol(tol), .locked(locked)
    );
endmodule

// File: rtl/freq_lock_ctrl_chk.sv
module freq_lock_ctrl_chk #(
    parameter int ERR_W = 18
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic                    up,
    input logic                    dn,
    input logic                    locked,
    input logic                    win_done,
    input logic signed [ERR_W-1:0] err_q,
    input logic [ERR_W-2:0]        tol
);
    logic [ERR_W-1:0] err_abs;
    logic             over_tol;

    assign err_abs  = err_q[ERR_W-1] ? ERR_W'(-err_q) : ERR_W'(err_q);
    assign over_tol = err_abs > {1'b0, tol};

    // R5
    a_r5_up_dn_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

    // R6
    a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!up && !dn && !locked));

    // R8
    a_r8_drop_on_bad_window: assert property (@(posedge clk) disable iff (!rst_n)
        (en && win_done && over_tol) |=> !locked);

    // R7
    a_r7_rise_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(win_done));

    // R1
    a_r1_error_held: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !win_done) |-> $stable(err_q));
endmodule

bind freq_lock_ctrl freq_lock_ctrl_chk #(.ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .up(up), .dn(dn), .locked(locked),
    .win_done(win_done), .err_q(err_q), .tol(tol)
);

// File: tb/sim_freq_lock_ctrl.sv
module sim_freq_lock_ctrl;
    localparam int W = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        osc_stb = 1'b0;
    logic [15:0] win_len = 16'(W);
    logic [16:0] exp_cnt = '0;
    logic [16:0] offset = '0;
    logic [16:0] tol = '0;
    logic        up, dn, locked;

    int stb_div = 1;
    int ph = 0;
    int checks = 0;
    int fails = 0;
    int obs_up, obs_dn, obs_both;
    bit done = 1'b0;

    typedef struct {
        string req;
        int    up_lo;
        int    up_hi;
        int    dn_lo;
        int    dn_hi;
    } exp_t;

    exp_t sb_q[$];
    event span_done;

    freq_lock_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .osc_stb(osc_stb),
        .win_len(win_len), .exp_cnt(exp_cnt), .offset(offset), .tol(tol),
        .up(up), .dn(dn), .locked(locked)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        ph <= ph + 1;
        if (stb_div == 0)      osc_stb <= 1'b0;
        else if (stb_div == 1) osc_stb <= 1'b1;
        else                   osc_stb <= ((ph % stb_div) == 0);
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input int w, input int e, input int o, input int t, input int sd);
        @(negedge clk);
        en      = 1'b0;
        win_len = 16'(w);
        exp_cnt = 17'(e);
        offset  = 17'(o);
        tol     = 17'(t);
        stb_div = sd;
        @(negedge clk);
        en = 1'b1;
    endtask

    // Driver: push the expected pulse counts, then count pulses over the span.
    task automatic span(input string req, input int len, input int ulo, input int uhi,
                        input int dlo, input int dhi);
        sb_q.push_back('{req, ulo, uhi, dlo, dhi});
        obs_up = 0; obs_dn = 0; obs_both = 0;
        repeat (len) begin
            @(negedge clk);
            obs_up += int'(up);
            obs_dn += int'(dn);
            if (up && dn) obs_both++;
        end
        -> span_done;
        @(negedge clk);
    endtask

    // Monitor: pop expected items and compare against observed counts.
    initial begin : monitor
        exp_t it;
        forever begin
            @(span_done);
            it = sb_q.pop_front();
            chk(obs_up >= it.up_lo && obs_up <= it.up_hi, {it.req, " up count"}, obs_up, it.up_lo);
            chk(obs_dn >= it.dn_lo && obs_dn <= it.dn_hi, {it.req, " dn count"}, obs_dn, it.dn_lo);
            chk(obs_both == 0, "R5 up and dn together", obs_both, 0);
        end
    end

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait_edges(3);
        chk(up == 1'b0 && dn == 1'b0 && locked == 1'b0, "R9 reset outputs",
            int'({up, dn, locked}), 0);
        rst_n = 1'b1;

        // R6: disabled block ignores strobes
        en = 1'b0; stb_div = 1;
        span("R6 strobes while disabled", 100, 0, 0, 0, 0);
        chk(locked == 1'b0, "R6 locked while disabled", int'(locked), 0);

        // R7: zero error, lock after exactly four good windows
        restart(W, 64, 0, 0, 1);
        wait_edges(3 * W + W / 2);
        chk(locked == 1'b0, "R7 three good windows", int'(locked), 0);
        wait_edges(W);
        chk(locked == 1'b1, "R7 four good windows", int'(locked), 1);
        span("R3 zero error", 4 * W, 0, 0, 0, 0);

        // R3: positive offset gives up density 64/256
        restart(W, 64, 64, 0, 1);
        wait_edges(2 * W);
        span("R3 positive offset", 4 * W, 63, 65, 0, 0);
        chk(locked == 1'b0, "R7 error beyond tolerance", int'(locked), 0);

        // R3: negative offset gives dn density 128/256
        restart(W, 64, -128, 0, 1);
        wait_edges(2 * W);
        span("R3 negative offset", 4 * W, 0, 0, 127, 129);

        // R2: count 64 minus expected 32
        restart(W, 32, 0, 0, 1);
        wait_edges(2 * W);
        span("R2 count minus expected", 4 * W, 31, 33, 0, 0);

        // R1: strobe every other cycle, 32 per window, offset -16
        restart(W, 32, -16, 0, 2);
        wait_edges(2 * W);
        span("R1 strobe counting", 4 * W, 0, 0, 15, 17);

        // R2: modulo wrap, 64 - 131070 = +66, offset -2
        restart(W, 131070, -2, 0, 1);
        wait_edges(2 * W);
        span("R2 modulo wrap", 4 * W, 63, 65, 0, 0);

        // R1: zero window length acts as one cycle
        restart(0, 1, 64, 0, 1);
        wait_edges(8);
        span("R1 zero window length", 4 * W, 63, 65, 0, 0);

        // R7 boundary and R8 drop
        restart(W, 64, 100, 100, 1);
        wait_edges(4 * W + W / 2);
        chk(locked == 1'b1, "R7 error equal to tolerance", int'(locked), 1);
        offset = 17'(101);
        wait_edges(W + W / 2);
        chk(locked == 1'b0, "R8 window above tolerance", int'(locked), 0);
        offset = 17'(-100);
        wait_edges(W);
        chk(locked == 1'b0, "R7 single good window", int'(locked), 0);

        // R4: saturation
        restart(W, 64, 65535, 0, 1);
        wait_edges(2 * W);
        span("R4 saturating accumulator", 1024, 1024, 1024, 0, 0);

        // R6: disable, then re-enable with zero error
        @(negedge clk);
        en = 1'b0;
        span("R6 outputs after disable", 100, 0, 0, 0, 0);
        chk(locked == 1'b0, "R6 lock after disable", int'(locked), 0);
        offset = '0;
        exp_cnt = 17'(64);
        @(negedge clk);
        en = 1'b1;
        span("R6 state cleared on disable", 2 * W, 0, 0, 0, 0);

        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule